// File: doc/BRIEF.md
# Two-Phase Self-Test Pattern Generator

This block drives a combinational logic cone during built-in self-test. After a start pulse it applies a fixed number of test words in two phases that do not overlap. In the first phase, the words come straight from a maximal-length shift-register sequence. In the second phase, that sequence keeps stepping from where it stopped. Each word is then remapped by a fixed combinational decoder into vectors aimed at faults that random words seldom reach. A single mode flag chooses, bit by bit, between the raw word and the decoded word. A decoded bit that equals its own raw bit is wired straight through, with no multiplexer.

Every response returned by the logic under test is folded into a multiple-input signature register. When the last response has been absorbed, the block raises done and freezes the signature. It also drives a pass flag, which is high when the signature equals a golden value fixed at build time. A new start after done repeats the same run exactly.

Top module: `mmbist_top`

## Requirements
- R1: After reset, pattern_vld_o, done_o and pass_o are low and signature_o is zero.
- R2: start_i is accepted only while no run is active and no response is still pending. One cycle after acceptance, the generator holds the seed, with default 5'b00001. The first applied word equals the seed.
- R3: The first PR_LEN applied words are consecutive generator states. Each next state is {s[3:0], s[4]^s[2]}, which is the polynomial x^5+x^3+1.
- R4: The next DET_LEN words are the decoder image of the continuing generator states x. The outputs are y0 = ~x4|x1, y1 = ~x3, y2 = (x2&~x3)|(~x2&~x4), y3 = ~x0 and y4 = x4.
- R5: Bit 4 of every applied word equals bit 4 of the generator state in both phases, with no mode switching on that bit.
- R6: pattern_vld_o is high for exactly PR_LEN+DET_LEN contiguous cycles per run, and never while done_o is high.
- R7: The signature is cleared on acceptance of start. In each cycle where pattern_vld_o is high, it becomes {sig[6:0],1'b0} ^ (sig[7] ? POLY : 0) ^ resp_i, with default POLY 8'h1D.
- R8: done_o rises one cycle after the last cycle with pattern_vld_o high. While done_o stays high, signature_o holds its value.
- R9: When done_o rises, pass_o is high exactly when signature_o equals GOLDEN.
- R10: A start pulse during a run is ignored: the word stream and the final signature stay unchanged.
- R11: A start after done clears done_o and reproduces the same word stream and signature.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse |
| pattern_o | output | PAT_W | Registered test word to the logic under test |
| pattern_vld_o | output | 1 | pattern_o carries a word of the current run |
| resp_i | input | RESP_W | Combinational response to pattern_o |
| done_o | output | 1 | Run finished, signature final |
| pass_o | output | 1 | Final signature equals GOLDEN |
| signature_o | output | RESP_W | Compactor contents |

## Verification
The assertions assume that resp_i is a pure function of pattern_o, settling in the same cycle. They also assume that start_i is a clean synchronous level, and that PR_LEN and DET_LEN are both at least one. The bench models the logic under test as a continuous combinational function of pattern_o. It drives start_i only at falling edges, for one cycle at a time. One of these pulses falls deliberately in the middle of a run, to show that it is ignored.

// File: rtl/mmbist_pkg.sv
package mmbist_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_RANDOM = 2'd1,
    PH_DETERM = 2'd2
  } phase_e;
endpackage

// File: rtl/mmbist_lfsr.sv
module mmbist_lfsr #(
  parameter int          W    = 5,
  parameter logic [W-1:0] TAPS = 5'b10100,
  parameter logic [W-1:0] SEED = 5'b00001
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         step,
  output logic [W-1:0] state
);
  logic fb;
  assign fb = ^(state & TAPS);

  always_ff @(posedge clk) begin
    if (rst || load) state <= SEED;
    else if (step)   state <= {state[W-2:0], fb};
  end

  // R3: a nonzero seed with a primitive polynomial never reaches zero
  assert_nonzero_state_R3: assert property (@(posedge clk) disable iff (rst)
    state != '0);
endmodule

// File: rtl/mmbist_decoder.sv
module mmbist_decoder #(
  parameter int W = 5
) (
  input  logic [W-1:0] x,
  output logic [W-1:0] y
);
  generate
    if (W == 5) begin : g_ref
      assign y[0] = ~x[4] | x[1];
      assign y[1] = ~x[3];
      assign y[2] = (x[2] & ~x[3]) | (~x[2] & ~x[4]);
      assign y[3] = ~x[0];
      assign y[4] = x[4];
    end else begin : g_generic
      assign y = ~{x[0], x[W-1:1]};
    end
  endgenerate
endmodule

// File: rtl/mmbist_switch.sv
module mmbist_switch #(
  parameter int           W           = 5,
  parameter logic [W-1:0] DIRECT_MASK = 5'b10000
) (
  input  logic [W-1:0] raw,
  input  logic [W-1:0] dec,
  input  logic         det_mode,
  output logic [W-1:0] vec
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (DIRECT_MASK[i]) begin : g_wire
      assign vec[i] = raw[i];
    end else begin : g_mux
      assign vec[i] = det_mode ? dec[i] : raw[i];
    end
  end
endmodule

// File: rtl/mmbist_misr.sv
module mmbist_misr #(
  parameter int           W    = 8,
  parameter logic [W-1:0] POLY = 8'h1D
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] sig,
  output logic [W-1:0] sig_next
);
  assign sig_next = {sig[W-2:0], 1'b0} ^ (sig[W-1] ? POLY : '0) ^ din;

  always_ff @(posedge clk) begin
    if (rst || clear) sig <= '0;
    else if (en)      sig <= sig_next;
  end

  // R7: contents move only when a response is being absorbed or on clear
  assert_hold_when_idle_R7: assert property (@(posedge clk) disable iff (rst)
    (!en && !clear) |=> $stable(sig));
endmodule

// File: rtl/mmbist_ctrl.sv
module mmbist_ctrl
  import mmbist_pkg::*;
#(
  parameter int PR_LEN  = 40,
  parameter int DET_LEN = 24
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic load,
  output logic step,
  output logic det_mode,
  output logic last
);
  localparam int TOTAL = PR_LEN + DET_LEN;
  localparam int CW    = $clog2(TOTAL + 1);
  localparam logic [CW-1:0] PR_END  = CW'(PR_LEN - 1);
  localparam logic [CW-1:0] ALL_END = CW'(TOTAL - 1);

  phase_e        phase_q;
  logic [CW-1:0] cnt_q;
  logic          drain_q;

  assign load     = start && (phase_q == PH_IDLE) && !drain_q;
  assign step     = (phase_q != PH_IDLE);
  assign det_mode = (phase_q == PH_DETERM);
  assign last     = step && (cnt_q == ALL_END);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      drain_q <= 1'b0;
    end else begin
      drain_q <= last;
      if (load) begin
        cnt_q   <= '0;
        phase_q <= PH_RANDOM;
      end else if (step) begin
        cnt_q <= cnt_q + 1'b1;
        if (last)                                         phase_q <= PH_IDLE;
        else if (phase_q == PH_RANDOM && cnt_q == PR_END) phase_q <= PH_DETERM;
      end
    end
  end

  // R4: the deterministic phase never falls back to the random phase
  assert_phase_order_R4: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_DETERM) |=> (phase_q != PH_RANDOM));
  // R10: a start request is never honoured during a run
  assert_no_restart_R10: assert property (@(posedge clk) disable iff (rst)
    step |-> !load);
endmodule

// File: rtl/mmbist_top.sv
module mmbist_top #(
  parameter int              PAT_W       = 5,
  parameter int              RESP_W      = 8,
  parameter int              PR_LEN      = 40,
  parameter int              DET_LEN     = 24,
  parameter logic [PAT_W-1:0]  LFSR_TAPS   = 5'b10100,
  parameter logic [PAT_W-1:0]  LFSR_SEED   = 5'b00001,
  parameter logic [PAT_W-1:0]  DIRECT_MASK = 5'b10000,
  parameter logic [RESP_W-1:0] MISR_POLY   = 8'h1D,
  parameter logic [RESP_W-1:0] GOLDEN      = 8'h00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  output logic [PAT_W-1:0]  pattern_o,
  output logic              pattern_vld_o,
  input  logic [RESP_W-1:0] resp_i,
  output logic              done_o,
  output logic              pass_o,
  output logic [RESP_W-1:0] signature_o
);
  logic              load, step, det_mode, last;
  logic [PAT_W-1:0]  lfsr_state, dec_word, vec;
  logic [RESP_W-1:0] sig, sig_next;
  logic [PAT_W-1:0]  pat_q;
  logic              vld_q, last_q, done_q, pass_q;

  mmbist_ctrl #(.PR_LEN(PR_LEN), .DET_LEN(DET_LEN)) u_ctrl (
    .clk(clk), .rst(rst), .start(start_i),
    .load(load), .step(step), .det_mode(det_mode), .last(last)
  );

  mmbist_lfsr #(.W(PAT_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) u_lfsr (
    .clk(clk), .rst(rst), .load(load), .step(step), .state(lfsr_state)
  );

  mmbist_decoder #(.W(PAT_W)) u_dec (.x(lfsr_state), .y(dec_word));

  mmbist_switch #(.W(PAT_W), .DIRECT_MASK(DIRECT_MASK)) u_sw (
    .raw(lfsr_state), .dec(dec_word), .det_mode(det_mode), .vec(vec)
  );

  mmbist_misr #(.W(RESP_W), .POLY(MISR_POLY)) u_misr (
    .clk(clk), .rst(rst), .clear(load), .en(vld_q),
    .din(resp_i), .sig(sig), .sig_next(sig_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pat_q  <= '0;
      vld_q  <= 1'b0;
      last_q <= 1'b0;
    end else begin
      vld_q  <= step;
      last_q <= last;
      if (step) pat_q <= vec;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || load) begin
      done_q <= 1'b0;
      pass_q <= 1'b0;
    end else if (vld_q && last_q) begin
      done_q <= 1'b1;
      pass_q <= (sig_next == GOLDEN);
    end
  end

  assign pattern_o     = pat_q;
  assign pattern_vld_o = vld_q;
  assign done_o        = done_q;
  assign pass_o        = pass_q;
  assign signature_o   = sig;

  // R3: random-phase words are the raw generator state
  assert_raw_word_R3: assert property (@(posedge clk) disable iff (rst)
    (step && !det_mode) |=> (pat_q == $past(lfsr_state)));
  // R5: directly matched bits follow the generator in every phase
  for (genvar i = 0; i < PAT_W; i++) begin : g_direct_chk
    if (DIRECT_MASK[i]) begin : g_on
      assert_direct_bit_R5: assert property (@(posedge clk) disable iff (rst)
        step |=> (pat_q[i] == $past(lfsr_state[i])));
    end
  end
  // R6: no word is presented once the run has finished
  assert_no_word_at_done_R6: assert property (@(posedge clk) disable iff (rst)
    !(done_q && vld_q));
  // R8: the signature is frozen while done is held
  assert_frozen_sig_R8: assert property (@(posedge clk) disable iff (rst)
    (done_q && !load) |=> $stable(sig));
endmodule

// File: tb/test_mmbist_top.sv
`timescale 1ns/1ps
module test_mmbist_top;
  localparam int          PW    = 5;
  localparam int          RW    = 8;
  localparam int          PR    = 40;
  localparam int          DET   = 24;
  localparam int          TOTAL = PR + DET;
  localparam logic [4:0]  SEED  = 5'b00001;
  localparam logic [7:0]  POLY  = 8'h1D;

  function automatic logic [4:0] lfsr_nx(input logic [4:0] s);
    return {s[3:0], s[4] ^ s[2]};
  endfunction
  function automatic logic [4:0] dec_f(input logic [4:0] x);
    logic [4:0] y;
    y[0] = ~x[4] | x[1];
    y[1] = ~x[3];
    y[2] = (x[2] & ~x[3]) | (~x[2] & ~x[4]);
    y[3] = ~x[0];
    y[4] = x[4];
    return y;
  endfunction
  function automatic logic [7:0] cut_f(input logic [4:0] p);
    return {p ^ {p[0], p[4:1]}, p[0] & p[1], p[2] | p[3], ^p};
  endfunction
  function automatic logic [7:0] misr_nx(input logic [7:0] s, input logic [7:0] d);
    return {s[6:0], 1'b0} ^ (s[7] ? POLY : 8'h00) ^ d;
  endfunction
  function automatic logic [7:0] gold_calc();
    logic [4:0] s;
    logic [7:0] g;
    s = SEED;
    g = '0;
    for (int k = 0; k < TOTAL; k++) begin
      g = misr_nx(g, cut_f(k < PR ? s : dec_f(s)));
      s = lfsr_nx(s);
    end
    return g;
  endfunction
  localparam logic [7:0] GOLD = gold_calc();

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 1'b0;
  logic [PW-1:0] pattern_o;
  logic          pattern_vld_o;
  logic [RW-1:0] resp_i;
  logic          done_o, pass_o;
  logic [RW-1:0] signature_o;

  always #4 clk = ~clk;
  assign resp_i = cut_f(pattern_o);

  mmbist_top #(.PAT_W(PW), .RESP_W(RW), .PR_LEN(PR), .DET_LEN(DET),
               .LFSR_SEED(SEED), .MISR_POLY(POLY), .GOLDEN(GOLD)) i_mmbist_top (
    .clk(clk), .rst(rst), .start_i(start_i), .pattern_o(pattern_o),
    .pattern_vld_o(pattern_vld_o), .resp_i(resp_i), .done_o(done_o),
    .pass_o(pass_o), .signature_o(signature_o)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  logic [4:0] exp_q[$];
  int idx_q[$];
  logic [7:0] exp_sig;
  int vld_count;
  int cyc = 0;
  int last_vld_cyc, done_cyc;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) cyc++;

  // driver: start pulse, then push the expected word stream
  task automatic drive_run();
    logic [4:0] s;
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    s = SEED;
    exp_sig = '0;
    vld_count = 0;
    for (int k = 0; k < TOTAL; k++) begin
      exp_q.push_back(k < PR ? s : dec_f(s));
      idx_q.push_back(k);
      s = lfsr_nx(s);
    end
  endtask

  // monitor: compare each applied word as it appears
  always @(negedge clk) begin
    if (!rst && pattern_vld_o) begin
      logic [4:0] e;
      int k;
      vld_count++;
      last_vld_cyc = cyc;
      if (exp_q.size() == 0) begin
        check(0, "R6", "unexpected word", pattern_o, 0);
      end else begin
        e = exp_q.pop_front();
        k = idx_q.pop_front();
        if (k == 0) check(pattern_o == e, "R2", "first word", pattern_o, e);
        else if (k < PR) check(pattern_o == e, "R3", "random word", pattern_o, e);
        else check(pattern_o == e, "R4", "decoded word", pattern_o, e);
        check(pattern_o[4] == e[4], "R5", "direct bit", pattern_o[4], e[4]);
        check(!done_o, "R6", "done during run", done_o, 0);
        exp_sig = misr_nx(exp_sig, cut_f(e));
      end
    end
  end

  task automatic wait_done();
    int n = 0;
    while (!done_o && n < 2000) begin
      @(negedge clk);
      n++;
    end
    done_cyc = cyc;
    check(done_o, "R8", "done timeout", done_o, 1);
  endtask

  task automatic end_checks(input string tag);
    logic [7:0] held;
    check(vld_count == TOTAL, "R6", {tag, " word count"}, vld_count, TOTAL);
    check(exp_q.size() == 0, "R6", {tag, " words missing"}, exp_q.size(), 0);
    check(done_cyc - last_vld_cyc == 1, "R8", {tag, " done timing"},
          done_cyc - last_vld_cyc, 1);
    check(signature_o == exp_sig, "R7", {tag, " signature"}, signature_o, exp_sig);
    check(pass_o == (signature_o == GOLD), "R9", {tag, " pass flag"}, pass_o, 1);
    held = signature_o;
    repeat (5) @(negedge clk);
    check(signature_o == held && done_o, "R8", {tag, " frozen signature"},
          signature_o, held);
    check(!pattern_vld_o, "R6", {tag, " valid after done"}, pattern_vld_o, 0);
  endtask

  initial begin
    #(8 * 150000);
    check(0, "WATCHDOG", "run hung", cyc, 0);
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(!pattern_vld_o, "R1", "valid after reset", pattern_vld_o, 0);
    check(!done_o, "R1", "done after reset", done_o, 0);
    check(!pass_o, "R1", "pass after reset", pass_o, 0);
    check(signature_o == 0, "R1", "signature after reset", signature_o, 0);

    // run 1: plain run
    drive_run();
    wait_done();
    end_checks("run1");

    // run 2: restart after done (R11), with a stray start mid-run (R10)
    drive_run();
    check(!done_o, "R11", "done cleared on restart", done_o, 0);
    repeat (10) @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(pattern_vld_o, "R10", "run continues after stray start", pattern_vld_o, 1);
    wait_done();
    end_checks("run2 R10 R11");
    check(signature_o == GOLD, "R11", "repeat signature", signature_o, GOLD);

    finish_up();
  end
endmodule